// File: doc/BRIEF.md
# I2C Master Bit-Level Engine

This block drives an open-drain I2C bus one bit-level operation at a time. A controller above it hands it a single command: a start condition (which turns into a repeated start when a transaction is already open), a stop condition, a one-bit write or a one-bit read. The engine runs the line sequence for that command and answers with a one-cycle done pulse, an error flag and, for reads, the sampled bit. Byte assembly, addressing and bus recovery are left to the controller.

Each line is modelled as a drive-low enable plus a sampled input level. All bus timing comes from one half-period length in system clocks, set by a divider input. After every SCL release the engine waits for the line to read high, so a slave may stretch the clock. If the line stays low for too long, the command ends with an error. Out of reset the engine releases both lines, waits one half-period and probes whether the bus is idle.

Top module: `i2c_bit_engine`

## Requirements
- R1: Under reset and after it, both drive-low outputs are 0 and the open-transaction flag is 0. The engine is busy for one half-period, then sets bus_ready_o to 1 only if SCL and SDA both read high.
- R2: One half-period lasts div_i clocks, and a div_i of 0 is treated as 1. A WRITE_BIT holds two plain half-period waits, so its length grows by 2 clocks per unit of div_i.
- R3: START (op 2'b00) with no open transaction samples SDA first. If SDA is low it ends with err_o=1 and drives nothing. Otherwise it pulls SDA low, waits a half-period, pulls SCL low and sets the open flag.
- R4: START while a transaction is open first releases SDA, waits a half-period, releases SCL, waits for SCL high and one more half-period, then runs the R3 sequence. On success it leaves both lines pulled low and the flag set.
- R5: STOP (op 2'b01) pulls SDA low, waits a half-period, releases SCL and waits for it high, waits a half-period, releases SDA and waits a half-period. If SDA then reads low it ends with err_o=1 and the flag stays set. Otherwise it clears the flag and leaves both lines released.
- R6: WRITE_BIT (op 2'b10) drives SDA low for cmd_bit_i=0 and releases it for 1. It then waits a half-period, releases SCL, waits a half-period and waits out stretching. If the bit is 1 and SDA reads low, it ends with err_o=1 and leaves SCL released. Otherwise it pulls SCL low and ends without error.
- R7: READ_BIT (op 2'b11) releases SDA, waits a half-period, releases SCL and waits for it high. One half-period later it copies SDA onto rbit_o, pulls SCL low and pulses done. rbit_o changes only together with done.
- R8: After an SCL release, SCL is polled at the release and at every half-period boundary. If it is still low after 10 half-periods, the command ends with err_o=1 and SCL stays released. A slave that lets SCL go high sooner lets the command complete normally.
- R9: Each accepted command gives exactly one single-cycle done pulse. A command presented while busy is ignored and gives no done pulse of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_i | input | DIV_W | Half-period length in clocks (0 acts as 1) |
| cmd_valid_i | input | 1 | Command request, taken only when idle |
| cmd_op_i | input | 2 | 00 START, 01 STOP, 10 WRITE_BIT, 11 READ_BIT |
| cmd_bit_i | input | 1 | Bit to write for WRITE_BIT |
| scl_i | input | 1 | Sampled SCL level (already synchronous) |
| sda_i | input | 1 | Sampled SDA level (already synchronous) |
| scl_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | Engine is running a command or the reset probe |
| done_o | output | 1 | One-cycle pulse at command end |
| err_o | output | 1 | Error result, valid with done_o |
| rbit_o | output | 1 | Bit sampled by the last READ_BIT |
| txn_open_o | output | 1 | A transaction is open (start sent, no stop yet) |
| bus_ready_o | output | 1 | Bus read idle at the reset probe |

## Verification
The bench drives a slave model that can hold SDA low or stretch SCL, and targets the fault paths in each command. These are a start on a busy bus, a collision on a written 1, a stop whose SDA stays low and a stretch beyond the poll limit. A design that skipped any of these checks would report success while the bus is wrong. A repeated start that did not release SDA before raising SCL would never show both lines released, and the bench catches that. Command lengths are measured at several divider values, including 0 and 1, to expose a half-period off by one. A second command issued mid-operation must leave no trace: an engine that took it would produce an extra done.

// File: rtl/i2cbe_pkg.sv
package i2cbe_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'b00,
    OP_STOP  = 2'b01,
    OP_WRITE = 2'b10,
    OP_READ  = 2'b11
  } op_e;

  typedef enum logic [4:0] {
    S_IDLE,
    S_WAIT,      // wait one half-period, then go to ret
    S_STR,       // wait for released SCL to read high, then go to ret
    P_PROBE,
    P_RS_REL,
    P_RS_SU,
    P_ST_CHK,
    P_ST_END,
    P_SP_REL,
    P_SP_SU,
    P_SP_RSDA,
    P_SP_CHK,
    P_WR_REL,
    P_WR_STR,
    P_WR_CHK,
    P_RD_REL,
    P_RD_SU,
    P_RD_SMP
  } st_e;

endpackage

// File: rtl/i2cbe_halfper.sv
module i2cbe_halfper #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic             edge_o
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  // a zero divider behaves as one clock per half-period
  assign last = (div_i == '0) ? '0 : div_i - 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt >= last) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick_o = run && (cnt >= last);
  assign edge_o = run && (cnt == '0);
endmodule

// File: rtl/i2cbe_seq.sv
module i2cbe_seq
  import i2cbe_pkg::*;
#(
  parameter int STRETCH_LIMIT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_valid_i,
  input  op_e  cmd_op_i,
  input  logic cmd_bit_i,
  input  logic scl_i,
  input  logic sda_i,
  input  logic tick_i,
  input  logic edge_i,
  output logic run_o,
  output logic scl_low_o,
  output logic sda_low_o,
  output logic busy_o,
  output logic done_o,
  output logic err_o,
  output logic rbit_o,
  output logic open_o,
  output logic ready_o
);
  localparam int SW = $clog2(STRETCH_LIMIT + 1);

  st_e           state, ret;
  logic [SW-1:0] scnt;
  logic          wbit;

  assign run_o  = (state == S_WAIT) || (state == S_STR);
  assign busy_o = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_WAIT;
      ret       <= P_PROBE;
      scl_low_o <= 1'b0;
      sda_low_o <= 1'b0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
      rbit_o    <= 1'b0;
      open_o    <= 1'b0;
      ready_o   <= 1'b0;
      scnt      <= '0;
      wbit      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        S_IDLE: if (cmd_valid_i) begin
          wbit <= cmd_bit_i;
          case (cmd_op_i)
            OP_START: if (open_o) begin
              sda_low_o <= 1'b0; state <= S_WAIT; ret <= P_RS_REL;
            end else begin
              state <= P_ST_CHK;
            end
            OP_STOP: begin
              sda_low_o <= 1'b1; state <= S_WAIT; ret <= P_SP_REL;
            end
            OP_WRITE: begin
              sda_low_o <= !cmd_bit_i; state <= S_WAIT; ret <= P_WR_REL;
            end
            default: begin
              sda_low_o <= 1'b0; state <= S_WAIT; ret <= P_RD_REL;
            end
          endcase
        end
        S_WAIT: if (tick_i) state <= ret;
        S_STR: if (edge_i) begin
          if (scl_i) begin
            scnt <= '0; state <= ret;
          end else if (scnt == SW'(STRETCH_LIMIT)) begin
            scnt <= '0; done_o <= 1'b1; err_o <= 1'b1; state <= S_IDLE;
          end else begin
            scnt <= scnt + 1'b1;
          end
        end
        P_PROBE: begin
          ready_o <= scl_i && sda_i; state <= S_IDLE;
        end
        P_RS_REL: begin scl_low_o <= 1'b0; state <= S_STR; ret <= P_RS_SU; end
        P_RS_SU:  begin state <= S_WAIT; ret <= P_ST_CHK; end
        P_ST_CHK: if (!sda_i) begin
          done_o <= 1'b1; err_o <= 1'b1; state <= S_IDLE;
        end else begin
          sda_low_o <= 1'b1; state <= S_WAIT; ret <= P_ST_END;
        end
        P_ST_END: begin
          scl_low_o <= 1'b1; open_o <= 1'b1;
          done_o <= 1'b1; err_o <= 1'b0; state <= S_IDLE;
        end
        P_SP_REL:  begin scl_low_o <= 1'b0; state <= S_STR; ret <= P_SP_SU; end
        P_SP_SU:   begin state <= S_WAIT; ret <= P_SP_RSDA; end
        P_SP_RSDA: begin sda_low_o <= 1'b0; state <= S_WAIT; ret <= P_SP_CHK; end
        P_SP_CHK: begin
          if (sda_i) open_o <= 1'b0;
          done_o <= 1'b1; err_o <= !sda_i; state <= S_IDLE;
        end
        P_WR_REL: begin scl_low_o <= 1'b0; state <= S_WAIT; ret <= P_WR_STR; end
        P_WR_STR: begin state <= S_STR; ret <= P_WR_CHK; end
        P_WR_CHK: begin
          if (wbit && !sda_i) begin
            err_o <= 1'b1;
          end else begin
            err_o <= 1'b0; scl_low_o <= 1'b1;
          end
          done_o <= 1'b1; state <= S_IDLE;
        end
        P_RD_REL: begin scl_low_o <= 1'b0; state <= S_STR; ret <= P_RD_SU; end
        P_RD_SU:  begin state <= S_WAIT; ret <= P_RD_SMP; end
        P_RD_SMP: begin
          rbit_o <= sda_i; scl_low_o <= 1'b1;
          done_o <= 1'b1; err_o <= 1'b0; state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2cbe_pkg::*;
#(
  parameter int DIV_W         = 16,
  parameter int STRETCH_LIMIT = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_op_i,
  input  logic             cmd_bit_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_low_o,
  output logic             sda_low_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             rbit_o,
  output logic             txn_open_o,
  output logic             bus_ready_o
);
  logic run, tick, hp_edge;

  i2cbe_halfper #(.DIV_W(DIV_W)) u_hp (
    .clk(clk), .rst(rst), .run(run), .div_i(div_i),
    .tick_o(tick), .edge_o(hp_edge)
  );

  i2cbe_seq #(.STRETCH_LIMIT(STRETCH_LIMIT)) u_seq (
    .clk(clk), .rst(rst),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(op_e'(cmd_op_i)), .cmd_bit_i(cmd_bit_i),
    .scl_i(scl_i), .sda_i(sda_i), .tick_i(tick), .edge_i(hp_edge),
    .run_o(run), .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rbit_o(rbit_o),
    .open_o(txn_open_o), .ready_o(bus_ready_o)
  );
endmodule

// File: rtl/i2cbe_checker.sv
module i2cbe_checker (
  input logic clk,
  input logic rst,
  input logic scl_low_o,
  input logic sda_low_o,
  input logic busy_o,
  input logic done_o,
  input logic rbit_o,
  input logic txn_open_o
);
  // R1: lines released and no open transaction right after reset
  a_r1_reset_released: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!scl_low_o && !sda_low_o && !txn_open_o));

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R9: done only follows a busy cycle
  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(busy_o));

  // R3: a transaction opens with both lines pulled low
  a_r3_open_both_low: assert property (@(posedge clk) disable iff (rst)
    $rose(txn_open_o) |-> (scl_low_o && sda_low_o));

  // R5: a transaction closes with both lines released
  a_r5_close_released: assert property (@(posedge clk) disable iff (rst)
    $fell(txn_open_o) |-> (!scl_low_o && !sda_low_o));

  // R7: the read bit changes only together with done
  a_r7_rbit_with_done: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(rbit_o));
endmodule

bind i2c_bit_engine i2cbe_checker u_chk (.*);

// File: tb/i2c_bit_engine_test.sv
module i2c_bit_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] div = 16'd4;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic        cmd_bit = 1'b0;
  logic        stretch = 1'b0;
  logic        slv_sda_low = 1'b0;
  logic        scl_i, sda_i;
  logic        scl_low_o, sda_low_o, busy_o, done_o, err_o, rbit_o, txn_open_o, bus_ready_o;

  int nchk = 0, nfail = 0, ndone = 0;
  bit qerr[$]; bit qrb[$]; bit qck[$]; string qtag[$];
  bit watch = 1'b0, saw_rel = 1'b0;

  always #4 clk = !clk;

  assign scl_i = !(scl_low_o || stretch);
  assign sda_i = !(sda_low_o || slv_sda_low);

  i2c_bit_engine uut (
    .clk(clk), .rst(rst), .div_i(div), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_bit_i(cmd_bit), .scl_i(scl_i), .sda_i(sda_i), .scl_low_o(scl_low_o),
    .sda_low_o(sda_low_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .rbit_o(rbit_o), .txn_open_o(txn_open_o), .bus_ready_o(bus_ready_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops one expected result per done pulse
  bit    m_err, m_rb, m_ck;
  string m_tag;
  always @(posedge clk) begin
    #2;
    if (!rst && done_o) begin
      ndone++;
      if (qerr.size() == 0) begin
        chk("R9 unexpected done", 1, 0);
      end else begin
        m_err = qerr.pop_front(); m_rb = qrb.pop_front();
        m_ck = qck.pop_front(); m_tag = qtag.pop_front();
        chk({m_tag, " err"}, int'(err_o), int'(m_err));
        if (m_ck) chk({m_tag, " rbit"}, int'(rbit_o), int'(m_rb));
      end
    end
  end

  always @(negedge clk)
    if (watch && !sda_low_o && !scl_low_o) saw_rel = 1'b1;

  task automatic run_cmd(input logic [1:0] op, input logic b, input bit eerr,
                         input bit erb, input bit ck, input string tag,
                         input bit spam, output int dur);
    int n0;
    qerr.push_back(eerr); qrb.push_back(erb); qck.push_back(ck); qtag.push_back(tag);
    n0 = ndone;
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op; cmd_bit = b;
    @(negedge clk); cmd_valid = 1'b0; dur = 1;
    if (spam) begin
      @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'b01; cmd_bit = 1'b0;
      @(negedge clk); cmd_valid = 1'b0; dur += 2;
    end
    while (ndone == n0) begin @(negedge clk); dur++; end
  endtask

  task automatic hold_scl(input int cycles);
    stretch = 1'b1;
    fork
      begin repeat (cycles) @(negedge clk); stretch = 1'b0; end
    join_none
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int d, da, db, dc, dd, n1;
    repeat (3) @(negedge clk);
    chk("R1 scl released in reset", int'(scl_low_o), 0);
    chk("R1 sda released in reset", int'(sda_low_o), 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    chk("R1 open flag clear", int'(txn_open_o), 0);
    chk("R1 bus ready on idle bus", int'(bus_ready_o), 1);
    chk("R1 not busy after probe", int'(busy_o), 0);

    run_cmd(2'b00, 1'b0, 0, 0, 0, "R3 start", 0, d);
    chk("R3 open after start", int'(txn_open_o), 1);
    chk("R3 scl low after start", int'(scl_low_o), 1);
    chk("R3 sda low after start", int'(sda_low_o), 1);

    run_cmd(2'b10, 1'b1, 0, 0, 0, "R6 write one", 0, d);
    chk("R6 sda released for one", int'(sda_low_o), 0);
    chk("R6 scl low after write", int'(scl_low_o), 1);
    run_cmd(2'b10, 1'b0, 0, 0, 0, "R6 write zero", 0, d);
    chk("R6 sda low for zero", int'(sda_low_o), 1);

    slv_sda_low = 1'b1;
    run_cmd(2'b11, 1'b0, 0, 0, 1, "R7 read zero", 0, d);
    slv_sda_low = 1'b0;
    run_cmd(2'b11, 1'b0, 0, 1, 1, "R7 read one", 0, d);
    chk("R7 scl low after read", int'(scl_low_o), 1);

    run_cmd(2'b11, 1'b0, 0, 1, 1, "R9 read with busy request", 1, d);
    n1 = ndone;
    repeat (40) @(negedge clk);
    chk("R9 no done from ignored request", ndone, n1);
    chk("R9 no leftover expectation", qerr.size(), 0);
    chk("R9 ignored stop left open", int'(txn_open_o), 1);

    slv_sda_low = 1'b1;
    run_cmd(2'b10, 1'b1, 1, 0, 0, "R6 collision on one", 0, d);
    chk("R6 scl left released on error", int'(scl_low_o), 0);
    slv_sda_low = 1'b0;

    run_cmd(2'b01, 1'b0, 0, 0, 0, "R5 stop", 0, d);
    chk("R5 open cleared", int'(txn_open_o), 0);
    chk("R5 scl released", int'(scl_low_o), 0);
    chk("R5 sda released", int'(sda_low_o), 0);

    slv_sda_low = 1'b1;
    run_cmd(2'b00, 1'b0, 1, 0, 0, "R3 start on busy sda", 0, d);
    chk("R3 sda not driven on fail", int'(sda_low_o), 0);
    chk("R3 open stays clear", int'(txn_open_o), 0);
    slv_sda_low = 1'b0;

    run_cmd(2'b00, 1'b0, 0, 0, 0, "R3 start again", 0, d);
    saw_rel = 1'b0; watch = 1'b1;
    run_cmd(2'b00, 1'b0, 0, 0, 0, "R4 repeated start", 0, d);
    watch = 1'b0;
    chk("R4 both lines released mid restart", int'(saw_rel), 1);
    chk("R4 open after restart", int'(txn_open_o), 1);
    chk("R4 lines low after restart", int'(scl_low_o && sda_low_o), 1);

    hold_scl(30);
    run_cmd(2'b10, 1'b0, 0, 0, 0, "R8 short stretch", 0, d);
    chk("R8 scl low after stretched write", int'(scl_low_o), 1);
    hold_scl(300);
    run_cmd(2'b10, 1'b0, 1, 0, 0, "R8 stretch timeout", 0, d);
    chk("R8 scl released on timeout", int'(scl_low_o), 0);
    wait (stretch == 1'b0);
    @(negedge clk);

    slv_sda_low = 1'b1;
    run_cmd(2'b01, 1'b0, 1, 0, 0, "R5 stop with sda held", 0, d);
    chk("R5 open kept on failed stop", int'(txn_open_o), 1);
    slv_sda_low = 1'b0;
    run_cmd(2'b01, 1'b0, 0, 0, 0, "R5 stop retry", 0, d);
    chk("R5 open cleared on retry", int'(txn_open_o), 0);

    run_cmd(2'b00, 1'b0, 0, 0, 0, "R2 start", 0, d);
    div = 16'd4; run_cmd(2'b10, 1'b0, 0, 0, 0, "R2 write div4", 0, da);
    div = 16'd8; run_cmd(2'b10, 1'b0, 0, 0, 0, "R2 write div8", 0, db);
    div = 16'd1; run_cmd(2'b10, 1'b0, 0, 0, 0, "R2 write div1", 0, dc);
    div = 16'd0; run_cmd(2'b10, 1'b0, 0, 0, 0, "R2 write div0", 0, dd);
    chk("R2 div8 minus div4 length", db - da, 8);
    chk("R2 div4 minus div1 length", da - dc, 6);
    chk("R2 div0 acts as div1", dd, dc);
    div = 16'd4;
    run_cmd(2'b01, 1'b0, 0, 0, 0, "R5 final stop", 0, d);

    @(negedge clk); rst = 1'b1; slv_sda_low = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    repeat (20) @(negedge clk);
    chk("R1 bus not ready with sda low", int'(bus_ready_o), 0);
    slv_sda_low = 1'b0;

    summary();
    $finish;
  end
endmodule